// File: doc/BRIEF.md
# Per-Line Edge Interrupt Controller

This block watches 24 digital input lines, grouped as three 8-bit banks, and latches an interrupt flag for a line when that line makes a transition of the direction chosen for it. Each line has three pieces of state: a direction bit (rising or falling), an arm bit that allows the line to raise a flag, and the sticky flag itself. The flags of each bank are folded into one bit of an 8-bit pending summary, and all flags together drive a single interrupt output.

The block sits behind a register bank that has already decoded the address and page. That bank hands over one write strobe per bank for the direction, arm and flag registers, together with a shared 8-bit write data byte. The block returns the current contents of all three register groups and the summary so the bank can serve reads. The line levels arrive already synchronized to the block clock.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the direction, arm and flag registers are all zero, the summary is zero and `irq_o` is low.
- R2: With direction bit 1 and arm bit 1, a line that was 0 at one clock edge and is 1 at the next sets its flag at that next edge.
- R3: With direction bit 0 and arm bit 1, a line that goes from 1 to 0 between two clock edges sets its flag at the second edge.
- R4: A transition opposite to the line's direction, or any transition on a line whose arm bit is 0, leaves its flag unchanged.
- R5: Writing bank k of the arm register stores the write byte; every bit written as 0 also clears the flag of that line in the same edge, while flags of bits written as 1 and of other banks are unaffected.
- R6: A write strobe to flag bank k, whatever the data byte, clears all eight flags of bank k (lines 8k to 8k+7) and no flag of another bank.
- R7: When a qualifying transition reaches a line in the same edge as a clear of its flag bank, the flag ends up set.
- R8: Summary bit k (k = 0, 1, 2) is 1 exactly when some flag of bank k is set; summary bits 7 to 3 are always 0.
- R9: `irq_o` is 1 exactly when at least one of the 24 flags is set.
- R10: A write strobe to bank k of the direction register stores the write byte in lines 8k to 8k+7 (bit b for line 8k+b), visible after that edge.
- R11: A set flag stays set through later transitions of its line until it is cleared by R5 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_lvl_i | input | 24 | Synchronized line levels, bit 8k+b is bank k bit b |
| dir_wr_i | input | 3 | Direction register write strobe, one per bank |
| arm_wr_i | input | 3 | Arm register write strobe, one per bank |
| flag_wr_i | input | 3 | Flag register clear strobe, one per bank |
| wr_data_i | input | 8 | Write data byte shared by all strobes |
| dir_o | output | 24 | Current direction bits |
| arm_o | output | 24 | Current arm bits |
| flag_o | output | 24 | Current latched flags |
| pend_o | output | 8 | Pending summary, one bit per bank |
| irq_o | output | 1 | Interrupt request, OR of all flags |

## Verification
The hardest situation to reach is a qualifying transition landing in exactly the edge where its bank is being cleared, because the line must have sat at the opposite level for a cycle first and the strobe must be lined up with the level change to the cycle. The bench drives levels and strobes together on the falling clock edge, so it can place a rising transition and a flag-bank clear into the same cycle while another flag of the same bank is set. A sweep takes every one of the 24 lines through both directions, armed and disarmed, and compares every output with a bench model after each edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // direction encoding of one line
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_dir_e;

   // upper limit on banks so the summary never needs more than one byte
   localparam int unsigned MAX_BANKS = 8;

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          RESET_LVL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] dir_i,
   output logic [WIDTH-1:0] hit_o
);
   import edge_irq_pkg::*;

   logic [WIDTH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= {WIDTH{RESET_LVL}};
      end else begin
         lvl_q <= lvl_i;
      end
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic up, down;
      assign up   = lvl_i[b] & ~lvl_q[b];
      assign down = ~lvl_i[b] & lvl_q[b];
      always_comb begin
         if (edge_dir_e'(dir_i[b]) == EDGE_RISE) begin
            hit_o[b] = up;
         end else begin
            hit_o[b] = down;
         end
      end
   end

endmodule

// File: rtl/edge_irq_cfg_bank.sv
module edge_irq_cfg_bank #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 3,
   localparam int unsigned LINES   = REG_W * NUM_REGS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] wr_i,
   input  logic [REG_W-1:0]    data_i,
   output logic [LINES-1:0]    q_o
);

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [REG_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (wr_i[k]) begin
            r_q <= data_i;
         end
      end
      assign q_o[k*REG_W +: REG_W] = r_q;
   end

endmodule

// File: rtl/edge_irq_flag_bank.sv
module edge_irq_flag_bank #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 3,
   localparam int unsigned LINES   = REG_W * NUM_REGS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LINES-1:0]    hit_i,
   input  logic [LINES-1:0]    arm_i,
   input  logic [NUM_REGS-1:0] arm_wr_i,
   input  logic [NUM_REGS-1:0] flag_wr_i,
   input  logic [REG_W-1:0]    wr_data_i,
   output logic [LINES-1:0]    flag_o
);

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [REG_W-1:0] set_v, wipe_v, drop_v, nxt_v, f_q;

      // qualified transitions for this bank
      assign set_v  = hit_i[k*REG_W +: REG_W] & arm_i[k*REG_W +: REG_W];
      // a write of any value to the flag bank empties it
      assign wipe_v = {REG_W{flag_wr_i[k]}};
      // arm bits written as zero drop their flags
      assign drop_v = arm_wr_i[k] ? ~wr_data_i : '0;
      // a fresh transition outlives a bank wipe, a disarm beats both
      assign nxt_v  = ((f_q & ~wipe_v) | set_v) & ~drop_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= '0;
         end else begin
            f_q <= nxt_v;
         end
      end
      assign flag_o[k*REG_W +: REG_W] = f_q;
   end

endmodule

// File: rtl/edge_irq_summary.sv
module edge_irq_summary #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned SUM_W    = 8,
   localparam int unsigned LINES   = REG_W * NUM_REGS
) (
   input  logic [LINES-1:0] flag_i,
   output logic [SUM_W-1:0] pend_o,
   output logic             irq_o
);

   logic [NUM_REGS-1:0] bank_any;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_or
      assign bank_any[k] = |flag_i[k*REG_W +: REG_W];
   end

   if (SUM_W > NUM_REGS) begin : g_pad
      assign pend_o = {{(SUM_W-NUM_REGS){1'b0}}, bank_any};
   end else begin : g_exact
      assign pend_o = bank_any;
   end

   assign irq_o = |bank_any;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned SUM_W    = 8,
   localparam int unsigned LINES   = REG_W * NUM_REGS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LINES-1:0]    line_lvl_i,
   input  logic [NUM_REGS-1:0] dir_wr_i,
   input  logic [NUM_REGS-1:0] arm_wr_i,
   input  logic [NUM_REGS-1:0] flag_wr_i,
   input  logic [REG_W-1:0]    wr_data_i,
   output logic [LINES-1:0]    dir_o,
   output logic [LINES-1:0]    arm_o,
   output logic [LINES-1:0]    flag_o,
   output logic [SUM_W-1:0]    pend_o,
   output logic                irq_o
);
   import edge_irq_pkg::*;

   if (REG_W < 1) begin : g_bad_w
      $error("edge_irq_ctrl: REG_W must be at least 1");
   end
   if (NUM_REGS < 1 || NUM_REGS > MAX_BANKS) begin : g_bad_n
      $error("edge_irq_ctrl: NUM_REGS out of range");
   end
   if (SUM_W < NUM_REGS) begin : g_bad_s
      $error("edge_irq_ctrl: SUM_W must cover one bit per bank");
   end

   logic [LINES-1:0] hit;

   edge_irq_cfg_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (dir_wr_i),
      .data_i (wr_data_i),
      .q_o    (dir_o)
   );

   edge_irq_cfg_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (arm_wr_i),
      .data_i (wr_data_i),
      .q_o    (arm_o)
   );

   edge_irq_detect #(.WIDTH(LINES), .RESET_LVL(1'b0)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (line_lvl_i),
      .dir_i (dir_o),
      .hit_o (hit)
   );

   edge_irq_flag_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit),
      .arm_i     (arm_o),
      .arm_wr_i  (arm_wr_i),
      .flag_wr_i (flag_wr_i),
      .wr_data_i (wr_data_i),
      .flag_o    (flag_o)
   );

   edge_irq_summary #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .SUM_W(SUM_W)) u_sum (
      .flag_i (flag_o),
      .pend_o (pend_o),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned SUM_W    = 8,
   localparam int unsigned LINES   = REG_W * NUM_REGS
) (
   input logic                clk,
   input logic                rst_n,
   input logic [LINES-1:0]    line_lvl_i,
   input logic [NUM_REGS-1:0] dir_wr_i,
   input logic [NUM_REGS-1:0] arm_wr_i,
   input logic [NUM_REGS-1:0] flag_wr_i,
   input logic [REG_W-1:0]    wr_data_i,
   input logic [LINES-1:0]    dir_o,
   input logic [LINES-1:0]    arm_o,
   input logic [LINES-1:0]    flag_o,
   input logic [SUM_W-1:0]    pend_o,
   input logic                irq_o
);

   logic [LINES-1:0] lvl_d, qual, wipe_m, drop_m;
   logic [SUM_W-1:0] pend_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= line_lvl_i;
   end

   assign qual = arm_o & ((dir_o & line_lvl_i & ~lvl_d) | (~dir_o & ~line_lvl_i & lvl_d));

   always_comb begin
      pend_exp = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         wipe_m[k*REG_W +: REG_W] = {REG_W{flag_wr_i[k]}};
         drop_m[k*REG_W +: REG_W] = arm_wr_i[k] ? ~wr_data_i : '0;
         pend_exp[k] = (flag_o[k*REG_W +: REG_W] != '0);
      end
   end

   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flag_o == '0 && dir_o == '0 && arm_o == '0 && !irq_o));

   // R2, R3 and R7: a qualifying transition not disarmed in the same edge is latched
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_o & $past(qual & ~drop_m)) == $past(qual & ~drop_m)));

   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_o & ~$past(flag_o) & ~$past(qual)) == '0));

   p_disarm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(drop_m) & flag_o) == '0));

   p_bank_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_o & $past(wipe_m) & ~$past(qual)) == '0));

   p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == pend_exp));

   p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o == (flag_o != '0)));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_o) & ~$past(wipe_m | drop_m) & ~flag_o) == '0));

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_cfg
      p_dir_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(dir_wr_i[k]) |-> (dir_o[k*REG_W +: REG_W] == $past(wr_data_i)));
   end

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .SUM_W(SUM_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_lvl_i (line_lvl_i),
   .dir_wr_i   (dir_wr_i),
   .arm_wr_i   (arm_wr_i),
   .flag_wr_i  (flag_wr_i),
   .wr_data_i  (wr_data_i),
   .dir_o      (dir_o),
   .arm_o      (arm_o),
   .flag_o     (flag_o),
   .pend_o     (pend_o),
   .irq_o      (irq_o)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] lvl = '0;
   logic [2:0]  dir_wr = '0, arm_wr = '0, flag_wr = '0;
   logic [7:0]  wd = '0;
   logic [23:0] dir_q, arm_q, flag_q;
   logic [7:0]  pend_q;
   logic        irq_q;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic [23:0] m_dir = '0, m_arm = '0, m_flag = '0, m_prev = '0;

   always #10 clk = ~clk;

   edge_irq_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_lvl_i (lvl),
      .dir_wr_i   (dir_wr),
      .arm_wr_i   (arm_wr),
      .flag_wr_i  (flag_wr),
      .wr_data_i  (wd),
      .dir_o      (dir_q),
      .arm_o      (arm_q),
      .flag_o     (flag_q),
      .pend_o     (pend_q),
      .irq_o      (irq_q)
   );

   function automatic logic [7:0] pend_of(input logic [23:0] f);
      return {5'b0, |f[23:16], |f[15:8], |f[7:0]};
   endfunction

   task automatic check(input string tag, input logic [80:0] got, input logic [80:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // one clock: inputs already set (at a falling edge), model advanced, outputs compared
   task automatic step(input string tag);
      logic [23:0] up, down, qual, wipe, drop;
      up   = lvl & ~m_prev;
      down = ~lvl & m_prev;
      qual = m_arm & ((m_dir & up) | (~m_dir & down));
      wipe = '0;
      drop = '0;
      for (int k = 0; k < 3; k++) begin
         if (flag_wr[k]) wipe[k*8 +: 8] = 8'hFF;
         if (arm_wr[k])  drop[k*8 +: 8] = ~wd;
      end
      m_flag = ((m_flag & ~wipe) | qual) & ~drop;
      for (int k = 0; k < 3; k++) begin
         if (dir_wr[k]) m_dir[k*8 +: 8] = wd;
         if (arm_wr[k]) m_arm[k*8 +: 8] = wd;
      end
      m_prev = lvl;
      @(posedge clk);
      #1;
      check(tag, {dir_q, arm_q, flag_q, pend_q, irq_q},
            {m_dir, m_arm, m_flag, pend_of(m_flag), |m_flag});
      @(negedge clk);
      dir_wr = '0;
      arm_wr = '0;
      flag_wr = '0;
   endtask

   task automatic wr_dir(input int k, input logic [7:0] d, input string tag);
      dir_wr[k] = 1'b1; wd = d; step(tag);
   endtask
   task automatic wr_arm(input int k, input logic [7:0] d, input string tag);
      arm_wr[k] = 1'b1; wd = d; step(tag);
   endtask
   task automatic wr_flag(input int k, input string tag);
      flag_wr[k] = 1'b1; wd = 8'h5A; step(tag);
   endtask

   initial begin : watchdog
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset state", {dir_q, arm_q, flag_q, pend_q, irq_q}, '0);

      // R10: direction and arm read-back with distinct bytes
      wr_dir(0, 8'hA5, "R10 dir bank0");
      wr_dir(1, 8'h3C, "R10 dir bank1");
      wr_dir(2, 8'h81, "R10 dir bank2");
      wr_arm(0, 8'h0F, "R10 arm bank0");
      wr_arm(1, 8'hF0, "R10 arm bank1");
      wr_arm(2, 8'h66, "R10 arm bank2");

      // R2/R3 sweep over every line, both directions, armed
      for (int pv = 0; pv < 2; pv++) begin
         for (int k = 0; k < 3; k++) wr_dir(k, pv ? 8'hFF : 8'h00, "R10 dir set");
         for (int k = 0; k < 3; k++) wr_arm(k, 8'hFF, "R10 arm set");
         lvl = pv ? 24'h0 : 24'hFFFFFF;
         step("R4 idle level");
         for (int k = 0; k < 3; k++) wr_flag(k, "R6 clear idle");
         for (int i = 0; i < 24; i++) begin
            lvl[i] = ~lvl[i];
            step(pv ? "R2 rising edge" : "R3 falling edge");
            check(pv ? "R2 single flag" : "R3 single flag", {57'b0, flag_q}, {57'b0, 24'h1 << i});
            lvl[i] = ~lvl[i];
            step("R11 opposite edge keeps flag");
            check("R9 irq held", {80'b0, irq_q}, 81'b1);
            wr_flag(i / 8, "R6 bank clear");
            check("R6 flags empty", {57'b0, flag_q}, '0);
         end
      end

      // R4: disarmed lines ignore transitions in both directions
      for (int k = 0; k < 3; k++) wr_arm(k, 8'h00, "R5 disarm all");
      for (int i = 0; i < 24; i++) begin
         lvl[i] = ~lvl[i];
         step("R4 disarmed edge");
         lvl[i] = ~lvl[i];
         step("R4 disarmed edge back");
      end
      check("R4 no flag when disarmed", {57'b0, flag_q}, '0);

      // R5: disarming one line drops only its flag
      for (int k = 0; k < 3; k++) wr_arm(k, 8'hFF, "R10 arm set");
      for (int k = 0; k < 3; k++) wr_dir(k, 8'hFF, "R10 dir rise");
      lvl = '0;
      step("R4 settle low");
      for (int k = 0; k < 3; k++) wr_flag(k, "R6 clear");
      lvl[3] = 1'b1; lvl[12] = 1'b1; lvl[20] = 1'b1;
      step("R2 three lines");
      check("R8 summary all banks", {73'b0, pend_q}, {73'b0, 8'h07});
      wr_arm(1, 8'hEF, "R5 disarm line 12");
      check("R5 only line 12 dropped", {57'b0, flag_q}, {57'b0, 24'h100008});
      check("R8 summary bank1 idle", {73'b0, pend_q}, {73'b0, 8'h05});

      // R7: transition on line 5 in the same edge as bank 0 clear
      lvl[5] = 1'b1;
      wr_flag(0, "R7 edge with clear");
      check("R7 new edge survives clear", {57'b0, flag_q}, {57'b0, 24'h100020});
      check("R6 other bank kept", {80'b0, flag_q[20]}, 81'b1);

      // R5 with simultaneous edge: disarm wins
      lvl[6] = 1'b1;
      wr_arm(0, 8'hBF, "R5 disarm beats edge");
      check("R5 line 6 not set", {80'b0, flag_q[6]}, 81'b0);

      for (int k = 0; k < 3; k++) wr_flag(k, "R6 final clear");
      check("R9 irq low after clear", {80'b0, irq_q}, 81'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule